// File: doc/BRIEF.md
# Streaming Transaction Padder

This block sits between two split-channel streaming links. Each link has a header channel and a data channel, and each channel has its own valid/ready handshake. A header carries a transaction id, a length field and a free metadata word. The length field holds the number of data beats minus one. Every data beat carries a data word and the id of the transaction it belongs to.

The padder forwards each transaction unchanged. It then appends zero-filled beats until the byte count is a whole multiple of `PAD_BYTES`. The outgoing header carries the rounded-up length and a pad-byte count, which is the number of bytes that were added. Because that header must go out before any data, the new length is worked out from the incoming length when the header is accepted.

Only one transaction is open at a time. The next header is held off until the last padded beat has been taken downstream. `PAD_BYTES / (DATA_W/8)` must be a power of two, so that the rounded-up length always fits the length field.

Top module: `txn_padder`

## Requirements
- R1: During reset and in the first cycle after it, `in_hdr_ready` is 1, and both `out_hdr_valid` and `out_dat_valid` are 0.
- R2: `in_hdr_ready` is high only while no transaction is open. It drops in the cycle after a header is accepted. It returns high in the cycle after the last padded data beat has been taken downstream.
- R3: `out_hdr_valid` rises in the cycle after an input header is accepted. `out_hdr_id` equals the accepted id and `out_hdr_meta` equals the accepted metadata.
- R4: With G = PAD_BYTES/(DATA_W/8) beats per pad block, `out_hdr_len` equals ceil((L+1)/G)*G-1, where L is the incoming length.
- R5: `out_hdr_padcnt` equals (out_hdr_len - L) * (DATA_W/8). It is always below PAD_BYTES and a multiple of the beat size.
- R6: `out_dat_valid` and `in_dat_ready` stay low until the outgoing header has been accepted. The first data beat can be offered in the very next cycle.
- R7: The first L+1 output beats are the input beats in order, with data and id unchanged. In that phase `in_dat_ready` equals `out_dat_ready` and `out_dat_valid` equals `in_dat_valid`.
- R8: The beats that follow, out_hdr_len - L of them, have all-zero data and the id of the open transaction. `in_dat_ready` is 0 during these beats.
- R9: If a valid output is not taken, it holds its value into the next cycle. Exactly out_hdr_len+1 data beats leave for each transaction, with none lost and none repeated.
- R10: Input data beats offered while the header is still pending are not consumed. They are forwarded once the data phase starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_hdr_valid | input | 1 | Input header offered |
| in_hdr_ready | output | 1 | Input header accepted when valid |
| in_hdr_id | input | ID_W | Input transaction id |
| in_hdr_len | input | LEN_W | Input beat count minus one |
| in_hdr_meta | input | META_W | Metadata copied through |
| in_dat_valid | input | 1 | Input data beat offered |
| in_dat_ready | output | 1 | Input data beat accepted when valid |
| in_dat_data | input | DATA_W | Input data word |
| in_dat_id | input | ID_W | Input beat transaction id |
| out_hdr_valid | output | 1 | Output header offered |
| out_hdr_ready | input | 1 | Output header taken when valid |
| out_hdr_id | output | ID_W | Output transaction id |
| out_hdr_len | output | LEN_W | Padded beat count minus one |
| out_hdr_meta | output | META_W | Copied metadata |
| out_hdr_padcnt | output | $clog2(PAD_BYTES+1) | Bytes added by padding |
| out_dat_valid | output | 1 | Output data beat offered |
| out_dat_ready | input | 1 | Output data beat taken when valid |
| out_dat_data | output | DATA_W | Output data word |
| out_dat_id | output | ID_W | Output beat transaction id |

## Verification
The outgoing header is registered. It appears one cycle after the input header handshake, so the bench checks its fields at the first falling edge after that edge and at every stalled cycle until it is taken. Data beats are combinational in both phases. They appear in the same cycle as the input beat, or, for padding, the cycle after the previous beat, starting one edge after the header handshake. The bench therefore sets inputs at the falling edge and samples a moment later, within the same cycle. The bench sweeps every length of a small configuration, with and without stalls on both channels. The return of `in_hdr_ready` is checked exactly one edge after the final padded beat.

// File: rtl/padder_pkg.sv
package padder_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_DATA = 2'd2,
        ST_PAD  = 2'd3
    } pad_state_e;

    // Round a beat count up to a whole number of pad blocks.
    function automatic int unsigned round_up_beats(int unsigned beats, int unsigned per_block);
        return ((beats + per_block - 1) / per_block) * per_block;
    endfunction

endpackage

// File: rtl/padder_len_calc.sv
module padder_len_calc #(
    parameter int LEN_W      = 8,
    parameter int BPP        = 2,
    parameter int BEAT_BYTES = 8,
    parameter int PADW       = 5
) (
    input  logic [LEN_W-1:0] in_len,
    output logic [LEN_W-1:0] out_len,
    output logic [PADW-1:0]  pad_bytes
);
    import padder_pkg::*;

    logic [LEN_W:0] beats;
    int unsigned    total;
    int unsigned    extra;

    always_comb begin
        beats     = {1'b0, in_len} + 1'b1;
        total     = round_up_beats(32'(beats), BPP);
        extra     = total - 32'(beats);
        out_len   = LEN_W'(total - 1);
        pad_bytes = PADW'(extra * BEAT_BYTES);
    end
endmodule

// File: rtl/padder_ctrl.sv
module padder_ctrl #(
    parameter int LEN_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_hdr_fire,
    input  logic                   out_hdr_fire,
    input  logic                   beat_fire,
    input  logic [LEN_W-1:0]       in_len,
    input  logic [LEN_W-1:0]       out_len,
    output padder_pkg::pad_state_e state
);
    import padder_pkg::*;

    logic [LEN_W-1:0] beat_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            beat_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    beat_cnt <= '0;
                    if (in_hdr_fire) state <= ST_HDR;
                end
                ST_HDR: begin
                    if (out_hdr_fire) state <= ST_DATA;
                end
                ST_DATA: begin
                    if (beat_fire) begin
                        if (beat_cnt == in_len) begin
                            if (in_len == out_len) begin
                                state <= ST_IDLE;
                            end else begin
                                state    <= ST_PAD;
                                beat_cnt <= beat_cnt + 1'b1;
                            end
                        end else begin
                            beat_cnt <= beat_cnt + 1'b1;
                        end
                    end
                end
                ST_PAD: begin
                    if (beat_fire) begin
                        if (beat_cnt == out_len) state <= ST_IDLE;
                        else                      beat_cnt <= beat_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/padder_beat_mux.sv
module padder_beat_mux #(
    parameter int DATA_W = 64,
    parameter int ID_W   = 4
) (
    input  padder_pkg::pad_state_e state,
    input  logic [ID_W-1:0]        cur_id,
    input  logic                   in_dat_valid,
    input  logic [DATA_W-1:0]      in_dat_data,
    input  logic [ID_W-1:0]        in_dat_id,
    input  logic                   out_dat_ready,
    output logic                   in_dat_ready,
    output logic                   out_dat_valid,
    output logic [DATA_W-1:0]      out_dat_data,
    output logic [ID_W-1:0]        out_dat_id
);
    import padder_pkg::*;

    always_comb begin
        in_dat_ready  = 1'b0;
        out_dat_valid = 1'b0;
        out_dat_data  = '0;
        out_dat_id    = cur_id;
        case (state)
            ST_DATA: begin
                out_dat_valid = in_dat_valid;
                out_dat_data  = in_dat_data;
                out_dat_id    = in_dat_id;
                in_dat_ready  = out_dat_ready;
            end
            ST_PAD: begin
                out_dat_valid = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/txn_padder.sv
module txn_padder #(
    parameter int DATA_W    = 64,
    parameter int ID_W      = 4,
    parameter int LEN_W     = 8,
    parameter int META_W    = 16,
    parameter int PAD_BYTES = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           in_hdr_valid,
    output logic                           in_hdr_ready,
    input  logic [ID_W-1:0]                in_hdr_id,
    input  logic [LEN_W-1:0]               in_hdr_len,
    input  logic [META_W-1:0]              in_hdr_meta,
    input  logic                           in_dat_valid,
    output logic                           in_dat_ready,
    input  logic [DATA_W-1:0]              in_dat_data,
    input  logic [ID_W-1:0]                in_dat_id,
    output logic                           out_hdr_valid,
    input  logic                           out_hdr_ready,
    output logic [ID_W-1:0]                out_hdr_id,
    output logic [LEN_W-1:0]               out_hdr_len,
    output logic [META_W-1:0]              out_hdr_meta,
    output logic [$clog2(PAD_BYTES+1)-1:0] out_hdr_padcnt,
    output logic                           out_dat_valid,
    input  logic                           out_dat_ready,
    output logic [DATA_W-1:0]              out_dat_data,
    output logic [ID_W-1:0]                out_dat_id
);
    import padder_pkg::*;

    localparam int BEAT_BYTES = DATA_W / 8;
    localparam int BPP        = (PAD_BYTES >= BEAT_BYTES) ? PAD_BYTES / BEAT_BYTES : 1;
    localparam int PADW       = $clog2(PAD_BYTES + 1);

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [META_W-1:0] meta;
        logic [LEN_W-1:0]  in_len;
        logic [LEN_W-1:0]  out_len;
        logic [PADW-1:0]   padcnt;
    } open_hdr_t;

    pad_state_e       state;
    open_hdr_t        hdr_q;
    logic [LEN_W-1:0] calc_len;
    logic [PADW-1:0]  calc_pad;
    logic             in_hdr_fire;
    logic             out_hdr_fire;
    logic             beat_fire;

    assign in_hdr_ready = (state == ST_IDLE);
    assign in_hdr_fire  = in_hdr_valid && in_hdr_ready;
    assign out_hdr_valid = (state == ST_HDR);
    assign out_hdr_fire = out_hdr_valid && out_hdr_ready;
    assign beat_fire    = out_dat_valid && out_dat_ready;

    padder_len_calc #(
        .LEN_W(LEN_W), .BPP(BPP), .BEAT_BYTES(BEAT_BYTES), .PADW(PADW)
    ) u_len (
        .in_len   (in_hdr_len),
        .out_len  (calc_len),
        .pad_bytes(calc_pad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_q <= '0;
        end else if (in_hdr_fire) begin
            hdr_q.id      <= in_hdr_id;
            hdr_q.meta    <= in_hdr_meta;
            hdr_q.in_len  <= in_hdr_len;
            hdr_q.out_len <= calc_len;
            hdr_q.padcnt  <= calc_pad;
        end
    end

    padder_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .in_hdr_fire (in_hdr_fire),
        .out_hdr_fire(out_hdr_fire),
        .beat_fire   (beat_fire),
        .in_len      (hdr_q.in_len),
        .out_len     (hdr_q.out_len),
        .state       (state)
    );

    padder_beat_mux #(.DATA_W(DATA_W), .ID_W(ID_W)) u_mux (
        .state        (state),
        .cur_id       (hdr_q.id),
        .in_dat_valid (in_dat_valid),
        .in_dat_data  (in_dat_data),
        .in_dat_id    (in_dat_id),
        .out_dat_ready(out_dat_ready),
        .in_dat_ready (in_dat_ready),
        .out_dat_valid(out_dat_valid),
        .out_dat_data (out_dat_data),
        .out_dat_id   (out_dat_id)
    );

    assign out_hdr_id     = hdr_q.id;
    assign out_hdr_len    = hdr_q.out_len;
    assign out_hdr_meta   = hdr_q.meta;
    assign out_hdr_padcnt = hdr_q.padcnt;
endmodule

// File: rtl/padder_checker.sv
module padder_checker #(
    parameter int DATA_W    = 64,
    parameter int ID_W      = 4,
    parameter int LEN_W     = 8,
    parameter int META_W    = 16,
    parameter int PAD_BYTES = 16
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           in_hdr_valid,
    input logic                           in_hdr_ready,
    input logic                           in_dat_valid,
    input logic                           in_dat_ready,
    input logic                           out_hdr_valid,
    input logic                           out_hdr_ready,
    input logic [ID_W-1:0]                out_hdr_id,
    input logic [LEN_W-1:0]               out_hdr_len,
    input logic [$clog2(PAD_BYTES+1)-1:0] out_hdr_padcnt,
    input logic                           out_dat_valid,
    input logic                           out_dat_ready,
    input logic [DATA_W-1:0]              out_dat_data,
    input logic [ID_W-1:0]                out_dat_id
);
    localparam int BEAT_BYTES = DATA_W / 8;
    localparam int BPP        = (PAD_BYTES >= BEAT_BYTES) ? PAD_BYTES / BEAT_BYTES : 1;

    logic [ID_W-1:0] taken_id;
    always_ff @(posedge clk) begin
        if (rst)                                taken_id <= '0;
        else if (out_hdr_valid && out_hdr_ready) taken_id <= out_hdr_id;
    end

    assert_one_open_R2: assert property (@(posedge clk) disable iff (rst)
        in_hdr_valid && in_hdr_ready |=> !in_hdr_ready);

    assert_len_aligned_R4: assert property (@(posedge clk) disable iff (rst)
        out_hdr_valid |-> ((32'(out_hdr_len) + 1) % BPP) == 0);

    assert_padcnt_range_R5: assert property (@(posedge clk) disable iff (rst)
        out_hdr_valid |-> (32'(out_hdr_padcnt) < PAD_BYTES)
                          && ((32'(out_hdr_padcnt) % BEAT_BYTES) == 0));

    assert_no_early_data_R6: assert property (@(posedge clk) disable iff (rst)
        (in_hdr_ready || out_hdr_valid) |-> !out_dat_valid && !in_dat_ready);

    assert_pad_beat_R8: assert property (@(posedge clk) disable iff (rst)
        out_dat_valid && !in_dat_valid |-> out_dat_data == '0 && out_dat_id == taken_id);

    assert_hdr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        out_hdr_valid && !out_hdr_ready |=> out_hdr_valid && $stable(out_hdr_len)
                                            && $stable(out_hdr_id) && $stable(out_hdr_padcnt));

    assert_pad_hold_R9: assert property (@(posedge clk) disable iff (rst)
        out_dat_valid && !out_dat_ready && !in_dat_valid |=> out_dat_valid);
endmodule

bind txn_padder padder_checker #(
    .DATA_W(DATA_W), .ID_W(ID_W), .LEN_W(LEN_W), .META_W(META_W), .PAD_BYTES(PAD_BYTES)
) u_chk (.*);

// File: tb/txn_padder_tb.sv
module txn_padder_tb;
    localparam int DATA_W    = 16;
    localparam int ID_W      = 3;
    localparam int LEN_W     = 4;
    localparam int META_W    = 5;
    localparam int PAD_BYTES = 8;
    localparam int PADW      = $clog2(PAD_BYTES + 1);
    localparam int BEATB     = DATA_W / 8;
    localparam int G         = PAD_BYTES / BEATB;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_hdr_valid = 1'b0;
    logic              in_hdr_ready;
    logic [ID_W-1:0]   in_hdr_id = '0;
    logic [LEN_W-1:0]  in_hdr_len = '0;
    logic [META_W-1:0] in_hdr_meta = '0;
    logic              in_dat_valid = 1'b0;
    logic              in_dat_ready;
    logic [DATA_W-1:0] in_dat_data = '0;
    logic [ID_W-1:0]   in_dat_id = '0;
    logic              out_hdr_valid;
    logic              out_hdr_ready = 1'b0;
    logic [ID_W-1:0]   out_hdr_id;
    logic [LEN_W-1:0]  out_hdr_len;
    logic [META_W-1:0] out_hdr_meta;
    logic [PADW-1:0]   out_hdr_padcnt;
    logic              out_dat_valid;
    logic              out_dat_ready = 1'b0;
    logic [DATA_W-1:0] out_dat_data;
    logic [ID_W-1:0]   out_dat_id;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    txn_padder #(
        .DATA_W(DATA_W), .ID_W(ID_W), .LEN_W(LEN_W), .META_W(META_W), .PAD_BYTES(PAD_BYTES)
    ) u_dut (.*);

    task automatic chk(string req, bit ok, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    function automatic int beat_word(int id, int k);
        return 16'hA000 + id * 256 + k;
    endfunction

    task automatic run_txn(int len, int id, int meta, bit stall);
        int exp_len, exp_pad, j, k, cyc, hc;
        exp_len = ((len + 1 + G - 1) / G) * G - 1;
        exp_pad = (exp_len - len) * BEATB;
        // offer header
        @(negedge clk);
        in_hdr_valid = 1'b1;
        in_hdr_id    = ID_W'(id);
        in_hdr_len   = LEN_W'(len);
        in_hdr_meta  = META_W'(meta);
        #1;
        chk("R2 ready when idle", in_hdr_ready == 1'b1, int'(in_hdr_ready), 1);
        // header pending phase, first input beat already offered (R10)
        hc = 0;
        forever begin
            @(negedge clk);
            in_hdr_valid  = 1'b0;
            in_dat_valid  = 1'b1;
            in_dat_data   = DATA_W'(beat_word(id, 0));
            in_dat_id     = ID_W'(id);
            out_hdr_ready = !(stall && hc < 2);
            #1;
            chk("R3 hdr valid", out_hdr_valid == 1'b1, int'(out_hdr_valid), 1);
            chk("R3 hdr id", int'(out_hdr_id) == id, int'(out_hdr_id), id);
            chk("R3 hdr meta", int'(out_hdr_meta) == meta, int'(out_hdr_meta), meta);
            chk("R4 hdr len", int'(out_hdr_len) == exp_len, int'(out_hdr_len), exp_len);
            chk("R5 padcnt", int'(out_hdr_padcnt) == exp_pad, int'(out_hdr_padcnt), exp_pad);
            chk("R2 busy", in_hdr_ready == 1'b0, int'(in_hdr_ready), 0);
            chk("R6 no early data", out_dat_valid == 1'b0, int'(out_dat_valid), 0);
            chk("R10 input held", in_dat_ready == 1'b0, int'(in_dat_ready), 0);
            hc++;
            if (out_hdr_ready) break;
        end
        // data phase
        j = 0; k = 0; cyc = 0;
        while (j <= exp_len && cycles < 150000) begin
            @(negedge clk);
            cyc++;
            out_hdr_ready = 1'b0;
            out_dat_ready = !(stall && (cyc % 3 == 1));
            in_dat_valid  = (k <= len) && !(stall && (cyc % 4 == 2));
            in_dat_data   = DATA_W'(beat_word(id, k));
            in_dat_id     = ID_W'(id);
            #1;
            if (cyc == 1 && !stall)
                chk("R6 first beat next cycle", out_dat_valid == 1'b1, int'(out_dat_valid), 1);
            if (j <= len) begin
                chk("R7 ready follows", in_dat_ready == out_dat_ready, int'(in_dat_ready), int'(out_dat_ready));
                chk("R7 valid follows", out_dat_valid == in_dat_valid, int'(out_dat_valid), int'(in_dat_valid));
            end else begin
                chk("R8 input idle in pad", in_dat_ready == 1'b0, int'(in_dat_ready), 0);
                chk("R9 pad beat offered", out_dat_valid == 1'b1, int'(out_dat_valid), 1);
            end
            if (in_dat_valid && in_dat_ready) k++;
            if (out_dat_valid && out_dat_ready) begin
                if (j <= len) begin
                    chk("R7 data", int'(out_dat_data) == beat_word(id, j), int'(out_dat_data), beat_word(id, j));
                    chk("R7 id", int'(out_dat_id) == id, int'(out_dat_id), id);
                end else begin
                    chk("R8 zero data", out_dat_data == '0, int'(out_dat_data), 0);
                    chk("R8 id", int'(out_dat_id) == id, int'(out_dat_id), id);
                end
                j++;
            end
        end
        @(negedge clk);
        in_dat_valid  = 1'b0;
        out_dat_ready = 1'b1;
        #1;
        chk("R9 beat count", k == len + 1, k, len + 1);
        chk("R9 no extra beat", out_dat_valid == 1'b0, int'(out_dat_valid), 0);
        chk("R2 ready again", in_hdr_ready == 1'b1, int'(in_hdr_ready), 1);
        out_dat_ready = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 hdr ready in reset", in_hdr_ready == 1'b1, int'(in_hdr_ready), 1);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk("R1 hdr ready", in_hdr_ready == 1'b1, int'(in_hdr_ready), 1);
        chk("R1 hdr valid low", out_hdr_valid == 1'b0, int'(out_hdr_valid), 0);
        chk("R1 data valid low", out_dat_valid == 1'b0, int'(out_dat_valid), 0);
        for (int s = 0; s < 2; s++) begin
            for (int len = 0; len < (1 << LEN_W); len++) begin
                run_txn(len, (len + s) % (1 << ID_W), (len * 3 + s) % (1 << META_W), bit'(s));
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait (cycles >= 150000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule